// File: doc/BRIEF.md
# Byte-Wide EPROM Mode and Identifier Logic

This block is a clocked behavioural model of the control logic around a byte-wide programmable read-only memory. The storage is a parameterised array of registers. A synchronous reset stands in for ultraviolet erasure and sets every cell back to all ones. The control pins are active-low chip select, output enable and program strobe. Two boolean flags stand in for the analog levels: one says the programming supply is present, and one says an over-voltage is applied to the identifier address line. The pins select read, output disable, standby, program, program verify, program inhibit or identifier read.

Programming can only clear bits. The byte on the input bus is ANDed into the stored byte on every clock edge of a program cycle, so repeated pulses do no harm. The data bus is split into an input, an output and an output enable. Output data appears only after three delays, counted in clock edges, have elapsed: address settle, chip-select settle and output-enable settle. Until then the bus stays in high impedance and the output reads zero.

Top module: `eprom_ctl`

## Requirements
- R1: After reset (erasure) every array byte reads back as all ones (FFh).
- R2: With the program supply present, chip select low, program strobe low and output enable high, each rising clock edge replaces the addressed byte with the stored byte ANDed with the input byte. The bus is not driven during programming.
- R3: The bus is driven (data_oe = 1) only while chip select and output enable are both low. With output enable high, data_oe is 0 and data_out reads 00h.
- R4: With chip select high (standby), data_oe is 0 and data_out is 00h whatever the other inputs are.
- R5: With the program supply present, chip select and output enable low and program strobe high, the bus drives the stored byte at the address (program verify).
- R6: With the program supply present and chip select high, a low program strobe leaves the array unchanged (program inhibit).
- R7: With the program supply absent and the identifier flag set, if every address bit other than bit 0 and bit ID_BIT is zero, a read returns D5h when bit 0 is 0 and 0Eh when bit 0 is 1.
- R8: Both identifier bytes have odd parity over all eight bits, with bit 7 acting as the parity bit.
- R9: With the identifier flag set but any address bit other than bit 0 and bit ID_BIT nonzero, a read returns array data.
- R10: After the address changes, the bus stays undriven until T_ACC rising edges have captured the new address.
- R11: After chip select falls, the bus stays undriven until T_CE rising edges have seen it low.
- R12: After output enable falls, the bus stays undriven until T_OE rising edges have seen it low.
- R13: Without the program supply, the program strobe has no effect on the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; erases the array to all ones |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| pgm_n | input | 1 | Active-low program strobe |
| vpp_hi | input | 1 | Programming supply present |
| hv_id | input | 1 | Over-voltage on the identifier address line |
| addr | input | ADDR_W | Byte address |
| data_in | input | DATA_W | Byte to program |
| data_out | output | DATA_W | Read data, 0 when undriven |
| data_oe | output | 1 | Bus drive enable |

## Verification
The assertions check the following on every cycle. The bus drives only with both selects low, and never in standby. A driven bus means output enable and chip select were low at the previous edge and the address has not changed since then. Driven identifier bytes carry the right code and odd parity. Array writes occur only under the full program condition. Whether AND-only programming, inhibit, erasure and the exact edge at which each delay releases the bus behave correctly can only be shown by the bench. It does this by sweeping every address through program, verify and read, and by probing the bus edge by edge after each control change.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

   typedef enum logic [2:0] {
      M_STANDBY = 3'd0,
      M_DISABLE = 3'd1,
      M_READ    = 3'd2,
      M_PROG    = 3'd3,
      M_VERIFY  = 3'd4,
      M_INHIBIT = 3'd5,
      M_IDREAD  = 3'd6
   } eprom_mode_e;

   function automatic logic mode_drives(input eprom_mode_e m);
      return (m == M_READ) || (m == M_VERIFY) || (m == M_IDREAD);
   endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
   import eprom_pkg::*;
(
   input  logic        ce_n,
   input  logic        oe_n,
   input  logic        pgm_n,
   input  logic        vpp_hi,
   input  logic        id_hit,
   output eprom_mode_e mode
);

   always_comb begin
      if (ce_n) begin
         mode = vpp_hi ? M_INHIBIT : M_STANDBY;
      end else if (vpp_hi) begin
         if (!pgm_n && oe_n)       mode = M_PROG;
         else if (pgm_n && !oe_n)  mode = M_VERIFY;
         else                      mode = M_DISABLE;
      end else if (oe_n) begin
         mode = M_DISABLE;
      end else if (id_hit) begin
         mode = M_IDREAD;
      end else begin
         mode = M_READ;
      end
   end

endmodule

// File: rtl/eprom_dly_cnt.sv
module eprom_dly_cnt #(
   parameter int LIMIT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic done
);

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (!run)        cnt <= '0;
      else if (restart)     cnt <= CW'(1);
      else if (cnt != LIM)  cnt <= cnt + 1'b1;
   end

   assign done = run && !restart && (cnt == LIM);

endmodule

// File: rtl/eprom_array.sv
module eprom_array #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
      end else if (wr_en) begin
         cells[addr] <= cells[addr] & wdata;
      end
   end

   assign rdata = cells[addr];

endmodule

// File: rtl/eprom_ctl.sv
module eprom_ctl
   import eprom_pkg::*;
#(
   parameter int          ADDR_W   = 10,
   parameter int          DATA_W   = 8,
   parameter int          ID_BIT   = 9,
   parameter bit          ID_EN    = 1'b1,
   parameter logic [7:0]  MFR_CODE = 8'hD5,
   parameter logic [7:0]  DEV_CODE = 8'h0E,
   parameter int          T_ACC    = 3,
   parameter int          T_CE     = 2,
   parameter int          T_OE     = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              pgm_n,
   input  logic              vpp_hi,
   input  logic              hv_id,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe
);

   localparam logic [ADDR_W-1:0] ID_MASK =
      ~(ADDR_W'(1) | (ADDR_W'(1) << ID_BIT));

   // elaboration-time parameter checks
   if (T_ACC < 1) begin : g_bad_tacc
      $error("T_ACC must be at least 1");
   end
   if (T_CE < 1) begin : g_bad_tce
      $error("T_CE must be at least 1");
   end
   if (T_OE < 1) begin : g_bad_toe
      $error("T_OE must be at least 1");
   end
   if (ID_EN && (ADDR_W <= ID_BIT)) begin : g_bad_idbit
      $error("ID_BIT must lie inside the address");
   end
   if (ID_EN && (DATA_W != 8)) begin : g_bad_idw
      $error("identifier codes need an 8-bit data bus");
   end
   if (ID_EN && (($countones(MFR_CODE) % 2) != 1)) begin : g_bad_mpar
      $error("MFR_CODE must have odd parity");
   end
   if (ID_EN && (($countones(DEV_CODE) % 2) != 1)) begin : g_bad_dpar
      $error("DEV_CODE must have odd parity");
   end

   eprom_mode_e       mode;
   logic              id_hit;
   logic [DATA_W-1:0] id_byte;
   logic [DATA_W-1:0] arr_q;
   logic [ADDR_W-1:0] addr_q;
   logic              wr_en;
   logic              acc_ok, ce_ok, oe_ok;

   // identifier path: present or tied off
   if (ID_EN) begin : g_id
      assign id_hit  = hv_id && ((addr & ID_MASK) == '0);
      assign id_byte = DATA_W'(addr[0] ? DEV_CODE : MFR_CODE);
   end else begin : g_noid
      logic unused_id;
      assign unused_id = hv_id;
      assign id_hit    = 1'b0;
      assign id_byte   = '0;
   end

   eprom_mode_dec u_dec (
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .pgm_n  (pgm_n),
      .vpp_hi (vpp_hi),
      .id_hit (id_hit),
      .mode   (mode)
   );

   assign wr_en = (mode == M_PROG);

   eprom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (data_in),
      .rdata (arr_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= addr;
   end

   eprom_dly_cnt #(.LIMIT(T_ACC)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (1'b1),
      .restart (addr != addr_q),
      .done    (acc_ok)
   );

   eprom_dly_cnt #(.LIMIT(T_CE)) u_ce (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (!ce_n),
      .restart (1'b0),
      .done    (ce_ok)
   );

   eprom_dly_cnt #(.LIMIT(T_OE)) u_oe (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (!oe_n),
      .restart (1'b0),
      .done    (oe_ok)
   );

   always_comb begin
      data_oe  = mode_drives(mode) && acc_ok && ce_ok && oe_ok && (addr == addr_q);
      data_out = '0;
      if (data_oe) data_out = (mode == M_IDREAD) ? id_byte : arr_q;
   end

endmodule

// File: rtl/eprom_ctl_chk.sv
module eprom_ctl_chk #(
   parameter int         ADDR_W   = 10,
   parameter int         DATA_W   = 8,
   parameter int         ID_BIT   = 9,
   parameter bit         ID_EN    = 1'b1,
   parameter logic [7:0] MFR_CODE = 8'hD5,
   parameter logic [7:0] DEV_CODE = 8'h0E
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              pgm_n,
   input logic              vpp_hi,
   input logic              hv_id,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] data_out,
   input logic              data_oe,
   input logic              wr_en
);

   localparam logic [ADDR_W-1:0] OTHER_BITS =
      ~(ADDR_W'(1) | (ADDR_W'(1) << ID_BIT));

   logic id_sel;
   assign id_sel = ID_EN && data_oe && !vpp_hi && hv_id && ((addr & OTHER_BITS) == '0);

   // R3
   drive_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> (!ce_n && !oe_n));

   // R4
   standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> (!data_oe && (data_out == '0)));

   // R12
   oe_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> $past(!oe_n));

   // R11
   ce_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> $past(!ce_n));

   // R10
   addr_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> $stable(addr));

   // R7
   id_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      id_sel |-> (data_out == DATA_W'(addr[0] ? DEV_CODE : MFR_CODE)));

   // R8
   id_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      id_sel |-> (^data_out));

   // R2
   write_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (!ce_n && !pgm_n && oe_n && vpp_hi && !data_oe));

   // R13
   no_supply_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vpp_hi |-> !wr_en);

endmodule

bind eprom_ctl eprom_ctl_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .ID_BIT   (ID_BIT),
   .ID_EN    (ID_EN),
   .MFR_CODE (MFR_CODE),
   .DEV_CODE (DEV_CODE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ce_n     (ce_n),
   .oe_n     (oe_n),
   .pgm_n    (pgm_n),
   .vpp_hi   (vpp_hi),
   .hv_id    (hv_id),
   .addr     (addr),
   .data_out (data_out),
   .data_oe  (data_oe),
   .wr_en    (wr_en)
);

// File: tb/tb_eprom_ctl.sv
`timescale 1ns/1ps
module tb_eprom_ctl;

   localparam int AW    = 10;
   localparam int DEPTH = 1 << AW;
   localparam int T_ACC = 3;
   localparam int T_CE  = 2;
   localparam int T_OE  = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1;
   logic          vpp_hi = 1'b0, hv_id = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    data_in = 8'hFF;
   logic [7:0]    data_out;
   logic          data_oe;

   int nvec = 0;
   int nfail = 0;
   logic [7:0] model [DEPTH];

   always #5 clk = ~clk;

   eprom_ctl #(.ADDR_W(AW), .T_ACC(T_ACC), .T_CE(T_CE), .T_OE(T_OE)) dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
      .vpp_hi(vpp_hi), .hv_id(hv_id), .addr(addr), .data_in(data_in),
      .data_out(data_out), .data_oe(data_oe)
   );

   task automatic chk_bus(input string tag, input bit exp_oe, input logic [7:0] exp_d);
      logic [8:0] act, exp;
      act = {data_oe, data_out};
      exp = {exp_oe, exp_oe ? exp_d : 8'h00};
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: got oe/data %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // read at a, checking the bus stays quiet until T_ACC edges pass (R10)
   task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
      bit chg;
      @(negedge clk);
      chg = (a != addr);
      addr = a;
      #1;
      if (chg) begin
         chk_bus({tag, " R10 at address change"}, 1'b0, 8'h00);
         if (T_ACC > 1) begin
            repeat (T_ACC - 1) @(negedge clk);
            #1 chk_bus({tag, " R10 one edge early"}, 1'b0, 8'h00);
         end
      end
      @(negedge clk);
      #1 chk_bus(tag, 1'b1, exp);
   endtask

   task automatic pg(input logic [AW-1:0] a, input logic [7:0] d, input bit sel);
      @(negedge clk);
      addr = a; data_in = d; pgm_n = 1'b0;
      #1 chk_bus("R2/R4 bus quiet while programming", 1'b0, 8'h00);
      if (sel) model[a] = model[a] & d;
      @(negedge clk);
      pgm_n = 1'b1;
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;

      // reset state
      ce_n = 1'b0; oe_n = 1'b0;
      idle(3);
      #1 chk_bus("R1 bus quiet in reset", 1'b0, 8'h00);
      rst_n = 1'b1;
      idle(4);

      // R1 erased sweep
      for (int a = 1; a < DEPTH; a++) rd(AW'(a), 8'hFF, "R1 erased read");
      rd('0, 8'hFF, "R1 erased read addr 0");

      // R2 programming, two passes with AND semantics
      oe_n = 1'b1; vpp_hi = 1'b1;
      idle(2);
      for (int a = 0; a < DEPTH; a++) pg(AW'(a), 8'(a * 7 + 3), 1'b1);
      for (int a = 0; a < DEPTH; a += 4) pg(AW'(a), ~8'(a >> 2), 1'b1);

      // R6 inhibit: chip select high blocks writes
      ce_n = 1'b1;
      for (int a = 8; a < 16; a++) pg(AW'(a), 8'h00, 1'b0);
      #1 chk_bus("R4 standby with supply", 1'b0, 8'h00);
      ce_n = 1'b0;

      // R5 verify sweep
      @(negedge clk); oe_n = 1'b0;
      idle(4);
      for (int a = 0; a < DEPTH; a++) rd(AW'(a), model[a], "R5/R2/R6 verify read");

      // R13 strobe without supply
      @(negedge clk); vpp_hi = 1'b0; oe_n = 1'b1;
      idle(2);
      pg(AW'(5), 8'h00, 1'b0);
      pg(AW'(6), 8'h00, 1'b0);
      @(negedge clk); oe_n = 1'b0;
      idle(3);
      rd(AW'(5), model[5], "R13 strobe ignored");
      rd(AW'(6), model[6], "R13 strobe ignored");

      // R3 output disable
      @(negedge clk); oe_n = 1'b1;
      #1 chk_bus("R3 oe high", 1'b0, 8'h00);
      idle(4);
      #1 chk_bus("R3 oe high held", 1'b0, 8'h00);

      // R12 output enable delay
      @(negedge clk); oe_n = 1'b0;
      for (int k = 0; k <= T_OE; k++) begin
         if (k > 0) @(negedge clk);
         #1 chk_bus("R12 oe delay", k >= T_OE, model[6]);
      end

      // R4 standby, R11 chip select delay
      @(negedge clk); ce_n = 1'b1;
      #1 chk_bus("R4 standby", 1'b0, 8'h00);
      idle(3);
      #1 chk_bus("R4 standby held", 1'b0, 8'h00);
      @(negedge clk); ce_n = 1'b0;
      for (int k = 0; k <= T_CE; k++) begin
         if (k > 0) @(negedge clk);
         #1 chk_bus("R11 ce delay", k >= T_CE, model[6]);
      end

      // R7/R8 identifier bytes, R9 fall-through
      @(negedge clk); hv_id = 1'b1;
      rd(AW'(0), 8'hD5, "R7 manufacturer code");
      #1 begin nvec++; if (^data_out !== 1'b1) begin nfail++; $display("FAIL R8 parity: got %h expected odd", data_out); end end
      rd(AW'(1), 8'h0E, "R7 device code");
      #1 begin nvec++; if (^data_out !== 1'b1) begin nfail++; $display("FAIL R8 parity: got %h expected odd", data_out); end end
      rd(AW'(10'h201), 8'h0E, "R7 device code with id line bit set");
      rd(AW'(10'h200), 8'hD5, "R7 manufacturer code with id line bit set");
      rd(AW'(2), model[2], "R9 other bit set");
      rd(AW'(10'h101), model[10'h101], "R9 high bit set");
      rd(AW'(10'h081), model[10'h081], "R9 bit 7 set");
      @(negedge clk); hv_id = 1'b0;
      rd(AW'(0), model[0], "R9 flag clear reads array");

      // R1 erasure by reset
      @(negedge clk); rst_n = 1'b0;
      idle(2);
      @(negedge clk); rst_n = 1'b1;
      idle(4);
      rd(AW'(0), 8'hFF, "R1 erased after reset");
      for (int a = 1; a < 64; a++) rd(AW'(a), 8'hFF, "R1 erased after reset");

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule